// File: doc/BRIEF.md
# Parallel Flash Command Sequencer

A synthesizable model of the command front end of an asynchronous parallel NOR flash. Bus strobes are sampled on a system clock. Each clock cycle in which the chip is selected and write-enabled with output-enable high counts as one command write. A small state machine decodes multi-cycle unlock sequences into the operations below:

- word program
- sector erase, covering one or several sectors
- whole-array erase
- erase suspend and resume
- identification reads
- a bypass state in which a program takes only two writes

A register-based word array holds the data. While a program or erase is in progress, reads return status bits in place of array data.

The array has 64 words of 16 bits, split into four sectors. Program and erase durations are parameter cycle counts. The accelerate input forces the two-write program form while it is high.

Top module: `flash_cmd_seq`

## Requirements
- R1: A clock cycle is a command write only when `ceN`=0, `weN`=0 and `oeN`=1. Cycles with `oeN`=0 or `ceN`=1 leave the mode and the array unchanged.
- R2: After reset the block is in read-array mode, `busy`=0, and every word reads 16'hFFFF. A read cycle (`ceN`=0, `oeN`=0, `weN`=1) loads `rdata` at the clock edge. `rdata` holds its value between read cycles.
- R3: Normal program is four writes: 8'hAA at address 12'h555, 8'h55 at 12'h2AA, 8'hA0 at 12'h555, then the data at the target address. After PROG_CYC busy cycles the word becomes old AND data.
- R4: Writing 8'h20 as the third unlock cycle enters bypass. In bypass a program is 8'hA0 at any address followed by the data. 8'h90 followed by 8'h00 leaves bypass.
- R5: While `accel`=1, the two-write program form is accepted with no entry sequence. With `accel`=0 and bypass not entered, a lone 8'hA0 followed by data is ignored.
- R6: Third-cycle code 8'h90 selects identification reads. Word offset 0 returns MFR_ID and offset 1 returns DEV_ID on bits 7:0, with bits 15:8 at zero. 8'hF0 returns to array reads.
- R7: While busy, a read returns bit 7 = the complement of bit 7 of the data being programmed (0 during erase), bit 6 inverted on every status read, and all other bits 0.
- R8: Deselecting the chip (`ceN`=1) during an operation does not stop it; it completes on schedule.
- R9: Erase setup (unlock, 8'h80 at 12'h555, unlock) followed by 8'h30 at an address selects the sector given by address bits 5:4. Each further 8'h30 within WIN_CYC cycles adds a sector and restarts the window. When the window closes, ERASE_CYC busy cycles follow, and then every word of the chosen sectors is set to 16'hFFFF. Other sectors keep their contents.
- R10: After erase setup, 8'h10 at 12'h555 erases the whole array.
- R11: Any unexpected write inside an unlock or erase-setup sequence returns the block to read-array mode, and nothing is programmed.
- R12: Writing 8'hB0 during an erase suspends it: `busy`=0 and reads return array data. Writing 8'h30 resumes the erase, which then completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ceN | input | 1 | Chip select, active low |
| weN | input | 1 | Write strobe, active low |
| oeN | input | 1 | Output enable, active low |
| accel | input | 1 | Forces two-write programming while high |
| addr | input | 12 | Word address |
| wdata | input | 16 | Write data; commands in bits 7:0 |
| rdata | output | 16 | Read data, status or identification |
| busy | output | 1 | High while an operation or erase window runs |

## Verification
Program tests use data that clears different bit groups on the same word. This separates an AND merge from a plain overwrite, and the chosen data bit 7 values show whether the status bit 7 is inverted. Sequences are repeated with one cycle corrupted: output-enable low, wrong code, or a lone program code without bypass. These show whether the block decodes only complete and correctly strobed sequences. Erases mix multi-sector, suspended and whole-array cases, and neighbour words in sectors that were not selected are read back. This catches a wrong sector slice or a mask that is not accumulated.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 16;
  localparam int ARR_W  = 6;
  localparam int SECT_W = 2;
  localparam int NSECT  = 1 << SECT_W;
  localparam int NWORD  = 1 << ARR_W;
  localparam int WPS    = NWORD / NSECT;

  typedef enum logic [3:0] {
    M_READ, M_UNL1, M_UNL2, M_PROG, M_ERS1, M_ERS2, M_ERS3,
    M_EWIN, M_BUSY, M_SUSP, M_AUTO, M_BEXIT
  } mode_e;

  typedef struct packed {
    logic              prog;
    logic              erase;
    logic [NSECT-1:0]  mask;
    logic [ARR_W-1:0]  addr;
    logic [DATA_W-1:0] data;
    logic              showStatus;
    logic              showId;
    logic              stat7;
  } strobe_t;
endpackage

// File: rtl/fcs_ctrl.sv
module fcs_ctrl import fcs_pkg::*; #(
  parameter int PROG_CYC  = 8,
  parameter int ERASE_CYC = 40,
  parameter int WIN_CYC   = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              weN,
  input  logic              oeN,
  input  logic              accel,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output strobe_t           strb,
  output mode_e             mode
);
  localparam int CNT_MAX = (ERASE_CYC > PROG_CYC) ?
                           ((ERASE_CYC > WIN_CYC) ? ERASE_CYC : WIN_CYC) :
                           ((PROG_CYC > WIN_CYC) ? PROG_CYC : WIN_CYC);
  localparam int CNT_W = $clog2(CNT_MAX + 1);

  mode_e             state;
  logic              bypReg, stat7, isErase;
  logic [CNT_W-1:0]  cnt;
  logic [NSECT-1:0]  mask;
  logic [ARR_W-1:0]  pAddr;
  logic [DATA_W-1:0] pData;

  logic              wrCyc, at555, at2AA, effByp, done;
  logic [7:0]        cmd;
  logic [SECT_W-1:0] sect;

  assign wrCyc  = !ceN && !weN && oeN;
  assign cmd    = wdata[7:0];
  assign at555  = addr == ADDR_W'(12'h555);
  assign at2AA  = addr == ADDR_W'(12'h2AA);
  assign sect   = addr[ARR_W-1 -: SECT_W];
  assign effByp = bypReg | accel;
  assign done   = cnt == '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= M_READ; bypReg <= 1'b0; stat7 <= 1'b0; isErase <= 1'b0;
      cnt <= '0; mask <= '0; pAddr <= '0; pData <= '0;
    end else begin
      case (state)
        M_READ: if (wrCyc) begin
          if (effByp) begin
            if (cmd == 8'hA0) state <= M_PROG;
            else if (cmd == 8'h90) state <= M_BEXIT;
          end else if (cmd == 8'hAA && at555) state <= M_UNL1;
        end
        M_UNL1: if (wrCyc) state <= (cmd == 8'h55 && at2AA) ? M_UNL2 : M_READ;
        M_UNL2: if (wrCyc) begin
          state <= M_READ;
          if (at555) begin
            case (cmd)
              8'hA0:   state <= M_PROG;
              8'h80:   state <= M_ERS1;
              8'h90:   state <= M_AUTO;
              8'h20:   bypReg <= 1'b1;
              default: ;
            endcase
          end
        end
        M_PROG: if (wrCyc) begin
          pAddr <= addr[ARR_W-1:0]; pData <= wdata; stat7 <= ~wdata[7];
          isErase <= 1'b0; cnt <= CNT_W'(PROG_CYC - 1); state <= M_BUSY;
        end
        M_ERS1: if (wrCyc) state <= (cmd == 8'hAA && at555) ? M_ERS2 : M_READ;
        M_ERS2: if (wrCyc) state <= (cmd == 8'h55 && at2AA) ? M_ERS3 : M_READ;
        M_ERS3: if (wrCyc) begin
          state <= M_READ; stat7 <= 1'b0; isErase <= 1'b1;
          if (cmd == 8'h10 && at555) begin
            mask <= '1; cnt <= CNT_W'(ERASE_CYC - 1); state <= M_BUSY;
          end else if (cmd == 8'h30) begin
            mask <= NSECT'(1) << sect; cnt <= CNT_W'(WIN_CYC - 1); state <= M_EWIN;
          end
        end
        M_EWIN: if (wrCyc) begin
          if (cmd == 8'h30) begin
            mask <= mask | (NSECT'(1) << sect); cnt <= CNT_W'(WIN_CYC - 1);
          end else state <= M_READ;
        end else if (done) begin
          cnt <= CNT_W'(ERASE_CYC - 1); state <= M_BUSY;
        end else cnt <= cnt - 1'b1;
        M_BUSY: if (done) state <= M_READ;
                else if (isErase && wrCyc && cmd == 8'hB0) state <= M_SUSP;
                else cnt <= cnt - 1'b1;
        M_SUSP:  if (wrCyc && cmd == 8'h30) state <= M_BUSY;
        M_AUTO:  if (wrCyc && cmd == 8'hF0) state <= M_READ;
        M_BEXIT: if (wrCyc) begin
          state <= M_READ;
          if (cmd == 8'h00) bypReg <= 1'b0;
        end
        default: state <= M_READ;
      endcase
    end
  end

  always_comb begin
    strb.prog       = state == M_BUSY && done && !isErase;
    strb.erase      = state == M_BUSY && done && isErase;
    strb.mask       = mask;
    strb.addr       = pAddr;
    strb.data       = pData;
    strb.showStatus = state == M_BUSY || state == M_EWIN;
    strb.showId     = state == M_AUTO;
    strb.stat7      = stat7;
  end

  assign mode = state;
endmodule

// File: rtl/fcs_data.sv
module fcs_data import fcs_pkg::*; #(
  parameter logic [7:0] MFR_ID = 8'h3D,
  parameter logic [7:0] DEV_ID = 8'hC2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              weN,
  input  logic              oeN,
  input  logic [ARR_W-1:0]  addr,
  input  strobe_t           strb,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] memRd [NWORD];
  logic [DATA_W-1:0] statWord, idWord;
  logic              tog, rdCyc;

  assign rdCyc = !ceN && !oeN && weN;

  for (genvar g = 0; g < NWORD; g++) begin : gWord
    logic [DATA_W-1:0] word;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) word <= '1;
      else if (strb.erase && strb.mask[g / WPS]) word <= '1;
      else if (strb.prog && strb.addr == ARR_W'(g)) word <= word & strb.data;
    end
    assign memRd[g] = word;
  end

  always_comb begin
    statWord    = '0;
    statWord[7] = strb.stat7;
    statWord[6] = tog;
    idWord      = '0;
    case (addr[1:0])
      2'd0:    idWord[7:0] = MFR_ID;
      2'd1:    idWord[7:0] = DEV_ID;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdata <= '0; tog <= 1'b0;
    end else if (rdCyc) begin
      if (strb.showStatus) begin
        rdata <= statWord; tog <= ~tog;
      end else if (strb.showId) rdata <= idWord;
      else rdata <= memRd[addr];
    end
  end
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq import fcs_pkg::*; #(
  parameter int         PROG_CYC  = 8,
  parameter int         ERASE_CYC = 40,
  parameter int         WIN_CYC   = 16,
  parameter logic [7:0] MFR_ID    = 8'h3D,
  parameter logic [7:0] DEV_ID    = 8'hC2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              weN,
  input  logic              oeN,
  input  logic              accel,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              busy
);
  strobe_t strb;
  mode_e   curMode;

  fcs_ctrl #(.PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC), .WIN_CYC(WIN_CYC)) u_ctrl (
    .clk(clk), .rstN(rstN), .ceN(ceN), .weN(weN), .oeN(oeN), .accel(accel),
    .addr(addr), .wdata(wdata), .strb(strb), .mode(curMode)
  );

  fcs_data #(.MFR_ID(MFR_ID), .DEV_ID(DEV_ID)) u_data (
    .clk(clk), .rstN(rstN), .ceN(ceN), .weN(weN), .oeN(oeN),
    .addr(addr[ARR_W-1:0]), .strb(strb), .rdata(rdata)
  );

  assign busy = strb.showStatus;
endmodule

// File: rtl/fcs_check.sv
module fcs_check import fcs_pkg::*; (
  input logic              clk,
  input logic              rstN,
  input logic              ceN,
  input logic              weN,
  input logic              oeN,
  input logic              accel,
  input logic [7:0]        cmd,
  input logic [DATA_W-1:0] rdata,
  input logic              busy,
  input mode_e             mode
);
  logic rdCyc, wrCyc;
  assign rdCyc = !ceN && !oeN && weN;
  assign wrCyc = !ceN && !weN && oeN;

  assert_no_write_oe_R1: assert property (@(posedge clk) disable iff (!rstN)
    (mode == M_READ && !ceN && !weN && !oeN) |=> mode == M_READ);

  assert_rdata_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !rdCyc |=> $stable(rdata));

  assert_accel_entry_R5: assert property (@(posedge clk) disable iff (!rstN)
    (mode == M_READ && accel && wrCyc && cmd == 8'hA0) |=> mode == M_PROG);

  assert_id_upper_R6: assert property (@(posedge clk) disable iff (!rstN)
    (mode == M_AUTO && rdCyc) |=> rdata[DATA_W-1:8] == '0);

  assert_toggle_R7: assert property (@(posedge clk) disable iff (!rstN)
    (busy && rdCyc && $past(busy && rdCyc)) |=> rdata[6] != $past(rdata[6]));

  assert_status_low_R7: assert property (@(posedge clk) disable iff (!rstN)
    (busy && rdCyc) |=> rdata[5:0] == '0);

  assert_erase_bit7_R7: assert property (@(posedge clk) disable iff (!rstN)
    (mode == M_EWIN && rdCyc) |=> !rdata[7]);

  assert_deselect_R8: assert property (@(posedge clk) disable iff (!rstN)
    (mode == M_BUSY && ceN) |=> (mode == M_BUSY || mode == M_READ));
endmodule

bind flash_cmd_seq fcs_check u_chk (
  .clk(clk), .rstN(rstN), .ceN(ceN), .weN(weN), .oeN(oeN), .accel(accel),
  .cmd(wdata[7:0]), .rdata(rdata), .busy(busy), .mode(curMode)
);

// File: tb/flash_cmd_seq_bench.sv
`timescale 1ns/1ps
module flash_cmd_seq_bench;
  localparam int PC = 8, EC = 40, WC = 16;
  localparam logic [7:0] MFR = 8'h3D, DEV = 8'hC2;
  localparam int X_READ = 0, X_U1 = 1, X_U2 = 2, X_PROG = 3, X_E1 = 4, X_E2 = 5,
                 X_E3 = 6, X_WIN = 7, X_BUSY = 8, X_SUSP = 9, X_AUTO = 10, X_BEX = 11;

  logic clk = 1'b0, rstN = 1'b0, ceN = 1'b1, weN = 1'b1, oeN = 1'b1, accel = 1'b0;
  logic [11:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic busy;
  int nChk = 0, nFail = 0;
  bit run = 1'b0;
  string curReq = "R2";

  flash_cmd_seq #(.PROG_CYC(PC), .ERASE_CYC(EC), .WIN_CYC(WC), .MFR_ID(MFR), .DEV_ID(DEV))
    u_flash_cmd_seq (.clk(clk), .rstN(rstN), .ceN(ceN), .weN(weN), .oeN(oeN), .accel(accel),
                     .addr(addr), .wdata(wdata), .rdata(rdata), .busy(busy));

  always #2 clk = ~clk;

  // behavioural reference model
  int md, cnt, pA, sec, c;
  bit byp, s7, tg, isE, w, r;
  bit [3:0] msk;
  logic [15:0] mem [64];
  logic [15:0] pD, eR;

  always @(posedge clk) begin
    if (!rstN) begin
      md = X_READ; cnt = 0; byp = 0; s7 = 0; tg = 0; isE = 0; msk = 0;
      pA = 0; pD = 0; eR = 0;
      foreach (mem[i]) mem[i] = 16'hFFFF;
    end else begin
      w = !ceN && !weN && oeN;
      r = !ceN && !oeN && weN;
      c = int'(wdata[7:0]);
      sec = int'(addr[5:4]);
      if (r) begin
        if (md == X_BUSY || md == X_WIN) begin
          eR = 16'h0; eR[7] = s7; eR[6] = tg; tg = !tg;
        end else if (md == X_AUTO)
          eR = (addr[1:0] == 2'd0) ? {8'h0, MFR} : (addr[1:0] == 2'd1) ? {8'h0, DEV} : 16'h0;
        else eR = mem[addr[5:0]];
      end
      case (md)
        X_READ: if (w) begin
          if (byp || accel) begin
            if (c == 'hA0) md = X_PROG; else if (c == 'h90) md = X_BEX;
          end else if (c == 'hAA && addr == 12'h555) md = X_U1;
        end
        X_U1: if (w) md = (c == 'h55 && addr == 12'h2AA) ? X_U2 : X_READ;
        X_U2: if (w) begin
          md = X_READ;
          if (addr == 12'h555) begin
            if (c == 'hA0) md = X_PROG;
            else if (c == 'h80) md = X_E1;
            else if (c == 'h90) md = X_AUTO;
            else if (c == 'h20) byp = 1;
          end
        end
        X_PROG: if (w) begin
          pA = int'(addr[5:0]); pD = wdata; s7 = !wdata[7]; isE = 0; cnt = PC - 1; md = X_BUSY;
        end
        X_E1: if (w) md = (c == 'hAA && addr == 12'h555) ? X_E2 : X_READ;
        X_E2: if (w) md = (c == 'h55 && addr == 12'h2AA) ? X_E3 : X_READ;
        X_E3: if (w) begin
          md = X_READ; s7 = 0; isE = 1;
          if (c == 'h10 && addr == 12'h555) begin msk = 4'hF; cnt = EC - 1; md = X_BUSY; end
          else if (c == 'h30) begin msk = 0; msk[sec] = 1; cnt = WC - 1; md = X_WIN; end
        end
        X_WIN: if (w) begin
          if (c == 'h30) begin msk[sec] = 1; cnt = WC - 1; end else md = X_READ;
        end else if (cnt == 0) begin cnt = EC - 1; md = X_BUSY; end
        else cnt--;
        X_BUSY: if (cnt == 0) begin
          if (isE) begin for (int i = 0; i < 64; i++) if (msk[i/16]) mem[i] = 16'hFFFF; end
          else mem[pA] = mem[pA] & pD;
          md = X_READ;
        end else if (isE && w && c == 'hB0) md = X_SUSP;
        else cnt--;
        X_SUSP: if (w && c == 'h30) md = X_BUSY;
        X_AUTO: if (w && c == 'hF0) md = X_READ;
        X_BEX: if (w) begin md = X_READ; if (c == 0) byp = 0; end
        default: md = X_READ;
      endcase
    end
  end

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    nChk++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  always @(negedge clk) if (run)
    check({curReq, " cycle compare"}, {15'h0, busy, rdata},
          {15'h0, (md == X_BUSY || md == X_WIN), eR});

  task automatic busIdle(int n);
    repeat (n) begin ceN = 1; weN = 1; oeN = 1; @(negedge clk); end
  endtask
  task automatic busWr(logic [11:0] a, logic [15:0] d, logic oeLvl = 1'b1);
    ceN = 0; weN = 0; oeN = oeLvl; addr = a; wdata = d;
    @(negedge clk);
    ceN = 1; weN = 1; oeN = 1;
  endtask
  task automatic busRd(logic [11:0] a, output logic [15:0] v);
    ceN = 0; oeN = 0; weN = 1; addr = a;
    @(negedge clk);
    v = rdata;
    ceN = 1; oeN = 1;
  endtask
  task automatic readChk(logic [11:0] a, logic [15:0] exp, string req);
    logic [15:0] v;
    busRd(a, v);
    check(req, {16'h0, v}, {16'h0, exp});
  endtask
  task automatic unlock();
    busWr(12'h555, 16'h00AA); busWr(12'h2AA, 16'h0055);
  endtask
  task automatic waitDone();
    int k = 0;
    busIdle(1);
    while (busy && k < 400) begin busIdle(1); k++; end
  endtask
  task automatic progNormal(logic [11:0] a, logic [15:0] d);
    unlock(); busWr(12'h555, 16'h00A0); busWr(a, d); waitDone();
  endtask
  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
  endtask

  initial begin
    #(200000 * 4);
    nFail++;
    $display("FAIL watchdog: run did not end, got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [15:0] v1, v2;
    repeat (3) @(negedge clk);
    rstN = 1; run = 1;
    @(negedge clk);
    curReq = "R2";
    check("R2 busy after reset", {31'h0, busy}, 32'h0);
    readChk(12'd5, 16'hFFFF, "R2 erased after reset");

    curReq = "R1";
    busWr(12'h555, 16'h00AA, 1'b0); busWr(12'h2AA, 16'h0055, 1'b0);
    busWr(12'h555, 16'h00A0, 1'b0); busWr(12'd7, 16'h0000, 1'b0);
    busIdle(2);
    check("R1 no busy after oe-low writes", {31'h0, busy}, 32'h0);
    readChk(12'd7, 16'hFFFF, "R1 word untouched");

    curReq = "R3";
    unlock(); busWr(12'h555, 16'h00A0); busWr(12'd5, 16'h12F0);
    busRd(12'd5, v1); busRd(12'd5, v2);
    check("R7 program status bit7", {31'h0, v1[7]}, 32'h0);
    check("R7 status toggles", {31'h0, v2[6]}, {31'h0, ~v1[6]});
    check("R7 status low bits", {16'h0, v1 & 16'hFF3F}, 32'h0);
    waitDone();
    readChk(12'd5, 16'h12F0, "R3 programmed");
    progNormal(12'd5, 16'h0FFF);
    readChk(12'd5, 16'h02F0, "R3 program ANDs");

    curReq = "R11";
    unlock(); busWr(12'h555, 16'h0077); busWr(12'd7, 16'h0000); busIdle(2);
    check("R11 abort not busy", {31'h0, busy}, 32'h0);
    readChk(12'd7, 16'hFFFF, "R11 abort no program");

    curReq = "R6";
    unlock(); busWr(12'h555, 16'h0090);
    readChk(12'd0, {8'h0, MFR}, "R6 manufacturer id");
    readChk(12'd1, {8'h0, DEV}, "R6 device id");
    busWr(12'd0, 16'h00F0);
    readChk(12'd0, 16'hFFFF, "R6 back to array");

    curReq = "R4";
    unlock(); busWr(12'h555, 16'h0020);
    busWr(12'd0, 16'h00A0); busWr(12'd9, 16'h00FF); waitDone();
    readChk(12'd9, 16'h00FF, "R4 two-write program");
    busWr(12'd0, 16'h0090); busWr(12'd0, 16'h0000);
    busWr(12'd0, 16'h00A0); busWr(12'd9, 16'h0000); busIdle(2);
    check("R4 exit no busy", {31'h0, busy}, 32'h0);
    readChk(12'd9, 16'h00FF, "R4 exit ignores A0");

    curReq = "R5";
    accel = 1;
    busWr(12'd0, 16'h00A0); busWr(12'd10, 16'hF00F); waitDone();
    readChk(12'd10, 16'hF00F, "R5 accel program");
    accel = 0;
    busWr(12'd0, 16'h00A0); busWr(12'd10, 16'h0000); busIdle(2);
    check("R5 accel off no busy", {31'h0, busy}, 32'h0);
    readChk(12'd10, 16'hF00F, "R5 accel off ignored");

    curReq = "R8";
    unlock(); busWr(12'h555, 16'h00A0); busWr(12'd11, 16'h5555);
    busIdle(1);
    check("R8 busy while deselected", {31'h0, busy}, 32'h1);
    busIdle(PC + 1);
    check("R8 finished while deselected", {31'h0, busy}, 32'h0);
    readChk(12'd11, 16'h5555, "R8 result");

    curReq = "R9";
    progNormal(12'd40, 16'h1234);
    progNormal(12'd20, 16'h00AA);
    unlock(); busWr(12'h555, 16'h0080); unlock();
    busWr(12'd5, 16'h0030); busWr(12'd40, 16'h0030);
    busRd(12'd0, v1);
    check("R7 erase status bit7", {31'h0, v1[7]}, 32'h0);
    waitDone();
    readChk(12'd5, 16'hFFFF, "R9 sector0 erased");
    readChk(12'd10, 16'hFFFF, "R9 sector0 other word");
    readChk(12'd40, 16'hFFFF, "R9 sector2 erased");
    readChk(12'd20, 16'h00AA, "R9 sector1 kept");

    curReq = "R12";
    unlock(); busWr(12'h555, 16'h0080); unlock(); busWr(12'd20, 16'h0030);
    busIdle(WC + 4);
    busWr(12'd0, 16'h00B0); busIdle(1);
    check("R12 suspended not busy", {31'h0, busy}, 32'h0);
    readChk(12'd20, 16'h00AA, "R12 array readable");
    busWr(12'd0, 16'h0030); waitDone();
    readChk(12'd20, 16'hFFFF, "R12 resumed erase done");

    curReq = "R10";
    progNormal(12'd50, 16'h0F0F);
    readChk(12'd50, 16'h0F0F, "R10 pre-erase value");
    unlock(); busWr(12'h555, 16'h0080); unlock(); busWr(12'h555, 16'h0010);
    waitDone();
    readChk(12'd50, 16'hFFFF, "R10 chip erase word50");
    readChk(12'd11, 16'hFFFF, "R10 chip erase word11");

    busIdle(2);
    run = 0;
    summary();
    $finish;
  end
endmodule